// File: doc/BRIEF.md
# Column-Transposed Sliding Window Extractor

The block accepts a serial stream of one-bit black/white pixels from a line-scan sensor. Each pixel arrives with a strobe from the sensor side and carries its column address within the line. Internally the block keeps a column-organised buffer. Each buffer word holds the most recent lines of one column, with the lines stacked inside the word. The buffer is filled one row at a time and read out one column at a time.

For every accepted pixel a small state machine on the faster system clock does four things. It reads that column's word, folds the new pixel in as the newest line, and writes the word back. It then pushes the same word into a two-dimensional window register as its new rightmost column. The window therefore slides one column to the right per pixel, and a complete square sub-image is presented for every pixel strobe.

Downstream logic takes `win_data` whenever `win_valid` pulses.

Top module: `colwin_extractor`

## Requirements
- R1: While reset is low, and after its release, `win_valid` is 0 and `win_data` is all zeros until the first pixel has been processed.
- R2: After reset the block clears all `COLS` buffer words to zero, one word per system clock. A column seen for the first time after reset therefore reads as zero in every older line.
- R3: Each accepted pixel replaces its column word with the old word shifted left by one, with the new pixel in bit 0. Bit 0 is the newest line and bit `ROWS-1` the oldest, and a line older than `ROWS` lines is dropped.
- R4: The window is laid out so that the updated column word of the latest pixel sits in `win_data[ROWS-1:0]`. The column `k` places to its left sits in `win_data[k*ROWS +: ROWS]`. Each accepted pixel moves every column one slot to the left and drops the leftmost one.
- R5: Once at least `WIN` columns of the current line have entered the window, every accepted pixel yields exactly one `win_valid` pulse, one system clock long.
- R6: A pixel at column 0 starts a new line count. The first `WIN-1` pixels of a line produce no `win_valid` pulse, so no presented window spans two lines.
- R7: When `pix_strobe` rises just before system clock edge 1 and stays high for at least two clocks, `win_valid` is high only after the 8th rising edge. This assumes strobes at least 8 system clocks apart, and holds the same way for every pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, about ten times the pixel rate |
| rst_n | input | 1 | Active-low reset |
| pix_strobe | input | 1 | Pixel strobe from the sensor side; rising edge marks a new pixel |
| pix_data | input | 1 | Pixel value, 1 = black, 0 = white |
| pix_col | input | $clog2(COLS) | Column position of the pixel in its line |
| win_valid | output | 1 | One-clock pulse marking a fresh sub-image |
| win_data | output | ROWS*WIN | Sub-image, column-major, newest column in the low bits |

## Verification
Several kinds of line are fed through the block: all-black lines, which fill every word with ones and show that the oldest line falls off after `ROWS` lines; an alternating black/white pattern, which exposes any swap of bit order or column order in the window; and random lines checked against a bench model of the column words. A line cut short by an early column 0 shows that the valid count restarts. Each pixel is checked for the exact cycle of its valid pulse, or its absence, and each valid window is compared bit for bit with the model.

// File: rtl/colwin_extractor.sv
module colwin_extractor #(
  parameter int COLS = 1024,
  parameter int ROWS = 16,
  parameter int WIN  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pix_strobe,
  input  logic                      pix_data,
  input  logic [$clog2(COLS)-1:0]   pix_col,
  output logic                      win_valid,
  output logic [ROWS*WIN-1:0]       win_data
);
  localparam int AW = $clog2(COLS);
  localparam int WW = ROWS * WIN;
  localparam int CW = $clog2(WIN + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_MODWR, S_SHIFT, S_OUT} st_t;

  st_t             state;
  logic [2:0]      sync_q;
  logic            rise;
  logic            clearing;
  logic [AW-1:0]   clr_idx;
  logic [AW-1:0]   lat_col;
  logic            lat_pix;
  logic [ROWS-1:0] rd_q;
  logic [ROWS-1:0] col_reg;
  logic [ROWS-1:0] new_word;
  logic [CW-1:0]   cnt;
  logic [WW-1:0]   win_q;

  logic [ROWS-1:0] mem [COLS];
  logic            we;
  logic [AW-1:0]   waddr;
  logic [ROWS-1:0] wdata;

  assign rise     = sync_q[1] & ~sync_q[2];
  assign new_word = (rd_q << 1) | {{(ROWS-1){1'b0}}, lat_pix};
  assign we       = clearing | (state == S_MODWR);
  assign waddr    = clearing ? clr_idx : lat_col;
  assign wdata    = clearing ? '0 : new_word;
  assign win_data = win_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pix_strobe};

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (state == S_READ) rd_q <= mem[lat_col];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
    end else if (clearing) begin
      if (clr_idx == AW'(COLS - 1)) clearing <= 1'b0;
      else                          clr_idx  <= clr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      lat_col   <= '0;
      lat_pix   <= 1'b0;
      col_reg   <= '0;
      cnt       <= '0;
      win_q     <= '0;
      win_valid <= 1'b0;
    end else begin
      win_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (rise && !clearing) begin
            lat_col <= pix_col;
            lat_pix <= pix_data;
            state   <= S_READ;
          end
        S_READ:  state <= S_WAIT;
        S_WAIT:  state <= S_MODWR;
        S_MODWR: begin
          col_reg <= new_word;
          state   <= S_SHIFT;
        end
        S_SHIFT: begin
          win_q <= {win_q[WW-ROWS-1:0], col_reg};
          if (lat_col == '0)       cnt <= CW'(1);
          else if (cnt != CW'(WIN)) cnt <= cnt + 1'b1;
          state <= S_OUT;
        end
        S_OUT: begin
          win_valid <= (cnt == CW'(WIN));
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_valid_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> !win_valid);

  p_no_valid_while_clearing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !win_valid);

  p_read_before_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> $past(state == S_READ));

  p_newest_column_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OUT) |-> (win_q[ROWS-1:0] == col_reg));

  p_pixel_in_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT) |-> (col_reg[0] == lat_pix));

  p_valid_needs_full_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (cnt == CW'(WIN)));

  p_no_lost_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clearing) |-> (state == S_IDLE));
endmodule

// File: tb/colwin_extractor_tb.sv
module colwin_extractor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 64;
  localparam int ROWS = 16;
  localparam int WIN  = 16;
  localparam int AW   = $clog2(COLS);
  localparam int WW   = ROWS * WIN;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_strobe = 1'b0;
  logic          pix_data = 1'b0;
  logic [AW-1:0] pix_col = '0;
  logic          win_valid;
  logic [WW-1:0] win_data;

  int checks = 0;
  int fails  = 0;

  logic [ROWS-1:0] mem_m [COLS];
  logic [ROWS-1:0] win_m [WIN];
  int              cnt_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  colwin_extractor #(.COLS(COLS), .ROWS(ROWS), .WIN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_strobe(pix_strobe), .pix_data(pix_data),
    .pix_col(pix_col), .win_valid(win_valid), .win_data(win_data));

  function automatic logic [WW-1:0] exp_window();
    logic [WW-1:0] v;
    for (int k = 0; k < WIN; k++) v[k*ROWS +: ROWS] = win_m[k];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input int col, input bit p);
    int vcycle = 0;
    int nval = 0;
    bit exp_v;
    logic [WW-1:0] got = '0;
    @(negedge clk);
    pix_col = AW'(col);
    pix_data = p;
    pix_strobe = 1'b1;
    mem_m[col] = {mem_m[col][ROWS-2:0], p};
    for (int k = WIN - 1; k > 0; k--) win_m[k] = win_m[k-1];
    win_m[0] = mem_m[col];
    if (col == 0) cnt_m = 1;
    else if (cnt_m < WIN) cnt_m++;
    exp_v = (cnt_m == WIN);
    for (int i = 1; i <= 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 4) pix_strobe = 1'b0;
      if (win_valid) begin
        if (vcycle == 0) vcycle = i;
        nval++;
        if (i == 8) got = win_data;
      end
    end
    if (exp_v) begin
      check(vcycle == 8 && nval == 1, "R5/R7", "valid pulse timing",
            WW'(vcycle * 100 + nval), WW'(801));
      check(got == exp_window(), "R3/R4", "window contents", got, exp_window());
    end else begin
      check(nval == 0, "R6", "valid suppressed in line start", WW'(nval), '0);
    end
  endtask

  task automatic send_line(input int mode);
    for (int c = 0; c < COLS; c++) begin
      bit p;
      case (mode)
        0: p = 1'b1;
        1: p = 1'b0;
        2: p = c[0];
        default: p = 1'($urandom);
      endcase
      send(c, p);
    end
  endtask

  initial begin
    for (int c = 0; c < COLS; c++) mem_m[c] = '0;
    for (int k = 0; k < WIN; k++) win_m[k] = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(win_valid == 1'b0 && win_data == '0, "R1", "reset state",
          {win_data[WW-2:0], win_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(win_valid == 1'b0 && win_data == '0, "R1", "after release",
          {win_data[WW-2:0], win_valid}, '0);
    repeat (COLS + 8) @(negedge clk);
    send_line(2);
    check(win_data[ROWS-1:0] == 16'h0001 && win_data[2*ROWS-1:ROWS] == 16'h0000,
          "R2", "cleared words plus first line", WW'(win_data[2*ROWS-1:0]), WW'(32'h0000_0001));
    send_line(0);
    send_line(3);
    for (int c = 0; c < 20; c++) send(c, 1'($urandom));
    send_line(3);
    for (int l = 0; l < 16; l++) send_line(l < 14 ? 0 : 1);
    check(win_data[ROWS-1:0] == 16'hfffc, "R3", "oldest lines dropped",
          WW'(win_data[ROWS-1:0]), WW'(16'hfffc));
    send_line(3);
    send_line(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule